// File: doc/BRIEF.md
# Eight-Operation Arithmetic Logic Unit with Status Flags

This block is the combinational compute stage of a small datapath. It receives two operands, `opnd_a` and `opnd_b`, and a three-bit operation code. In the same cycle it returns a result word and four status flags: zero, negative, carry and signed overflow.

The eight operations are addition, subtraction, bitwise AND, OR and XOR, complement of A, and a one-place logical shift of A to the left or to the right. Addition and subtraction share one ripple carry chain. Subtraction is formed as A plus the complement of B plus one. The carry flag is the adder carry-out for addition and a borrow for subtraction. Overflow compares the carry into the top bit with the carry out of it. A shift puts the bit it pushes out of A onto the carry flag.

The block has no clock, reset or storage. A surrounding pipeline registers the outputs where it needs them. The data width is a parameter, with a default of 8.

Top module: `alu8_core`

## Requirements
- R1: With `op_sel` = 3'b000, `result` equals (`opnd_a` + `opnd_b`) mod 256, and `flag_carry` is bit 8 of the 9-bit sum.
- R2: With `op_sel` = 3'b001, `result` equals (`opnd_a` − `opnd_b`) mod 256.
- R3: With `op_sel` = 3'b001, `flag_carry` is 1 exactly when `opnd_a` < `opnd_b` as unsigned numbers (a borrow).
- R4: For codes 3'b000 and 3'b001, `flag_ovf` is 1 exactly when the result read as two's complement differs from the true signed sum or difference. For example, 0x7F+0x01 sets it and 0xFF+0x01 does not.
- R5: Codes 3'b010, 3'b011 and 3'b100 give `opnd_a` AND, OR and XOR `opnd_b` respectively.
- R6: Code 3'b101 gives the bitwise complement of `opnd_a`.
- R7: Code 3'b110 gives `opnd_a` shifted left by one place, with 0 entering bit 0, and `flag_carry` equal to the old bit 7 of `opnd_a`.
- R8: Code 3'b111 gives `opnd_a` shifted right by one place, with 0 entering bit 7, and `flag_carry` equal to the old bit 0 of `opnd_a`.
- R9: For codes 3'b010 to 3'b101, `flag_carry` and `flag_ovf` are 0. For codes 3'b110 and 3'b111, `flag_ovf` is 0.
- R10: `flag_zero` is 1 exactly when all result bits are 0.
- R11: `flag_neg` equals bit 7 of `result`.
- R12: For codes 3'b101, 3'b110 and 3'b111, the value of `opnd_b` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code |
| opnd_a | input | 8 | First operand; the only operand of the unary operations |
| opnd_b | input | 8 | Second operand |
| result | output | 8 | Selected result word |
| flag_zero | output | 1 | Result is all zeros |
| flag_neg | output | 1 | Top bit of result |
| flag_carry | output | 1 | Carry out, borrow, or the bit shifted out |
| flag_ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The assertions are immediate checks on the settled combinational outputs. They assume the operands and `op_sel` carry known 0/1 values with no X or Z. The bench drives every input from a fixed-seed random source or from directed constants, so no unknown value reaches the block. Each operation code gets its own random batch. The signed and unsigned boundary pairs near 0x00, 0x7F, 0x80 and 0xFF are added as directed cases, so that both the carry flag and the overflow flag are driven to 1 and to 0.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100,
    OP_NOT = 3'b101,
    OP_SHL = 3'b110,
    OP_SHR = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu8_ripple_add.sv
// Ripple carry adder; exposes the carry into and out of the top bit.
module alu8_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         c_in,
  output logic [W-1:0] sum,
  output logic         c_top_in,
  output logic         c_out
);
  logic [W:0] chain;
  assign chain[0] = c_in;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a_in[i] ^ b_in[i] ^ chain[i];
    assign chain[i+1] = (a_in[i] & b_in[i]) | (chain[i] & (a_in[i] ^ b_in[i]));
  end

  assign c_top_in = chain[W-1];
  assign c_out    = chain[W];
endmodule

// File: rtl/alu8_bitwise.sv
// Bitwise logic section: AND, OR, XOR and complement of A.
module alu8_bitwise #(
  parameter int W = 8
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (sel)
        2'd0:    y[i] = a_in[i] & b_in[i];
        2'd1:    y[i] = a_in[i] | b_in[i];
        2'd2:    y[i] = a_in[i] ^ b_in[i];
        default: y[i] = ~a_in[i];
      endcase
    end
  end
endmodule

// File: rtl/alu8_shift1.sv
// One-place logical shift; direction chosen by parameter.
module alu8_shift1 #(
  parameter int W       = 8,
  parameter bit TO_LEFT = 1'b1
) (
  input  logic [W-1:0] a_in,
  output logic [W-1:0] y,
  output logic         out_bit
);
  if (TO_LEFT) begin : g_left
    assign y       = {a_in[W-2:0], 1'b0};
    assign out_bit = a_in[W-1];
  end else begin : g_right
    assign y       = {1'b0, a_in[W-1:1]};
    assign out_bit = a_in[0];
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int W = 8
) (
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         flag_zero,
  output logic         flag_neg,
  output logic         flag_carry,
  output logic         flag_ovf
);
  import alu8_pkg::*;

  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  // Shared adder: subtract as A + ~B + 1
  logic           is_sub;
  logic [W-1:0]   b_eff;
  logic [W-1:0]   sum;
  logic           c_top_in, c_out;
  assign is_sub = (op == OP_SUB);
  assign b_eff  = is_sub ? ~opnd_b : opnd_b;

  alu8_ripple_add #(.W(W)) u_add (
    .a_in(opnd_a), .b_in(b_eff), .c_in(is_sub),
    .sum(sum), .c_top_in(c_top_in), .c_out(c_out)
  );

  logic [W-1:0] logic_y;
  alu8_bitwise #(.W(W)) u_bit (
    .sel(op_sel[1:0] - 2'd2), .a_in(opnd_a), .b_in(opnd_b), .y(logic_y)
  );

  logic [W-1:0] shl_y, shr_y;
  logic         shl_out, shr_out;
  alu8_shift1 #(.W(W), .TO_LEFT(1'b1)) u_shl (.a_in(opnd_a), .y(shl_y), .out_bit(shl_out));
  alu8_shift1 #(.W(W), .TO_LEFT(1'b0)) u_shr (.a_in(opnd_a), .y(shr_y), .out_bit(shr_out));

  always_comb begin
    result     = '0;
    flag_carry = 1'b0;
    flag_ovf   = 1'b0;
    unique case (op)
      OP_ADD: begin result = sum;   flag_carry = c_out;  flag_ovf = c_top_in ^ c_out; end
      OP_SUB: begin result = sum;   flag_carry = ~c_out; flag_ovf = c_top_in ^ c_out; end
      OP_SHL: begin result = shl_y; flag_carry = shl_out; end
      OP_SHR: begin result = shr_y; flag_carry = shr_out; end
      default: result = logic_y;
    endcase
  end

  assign flag_zero = ~|result;
  assign flag_neg  = result[W-1];

  // Checks against operand-level arithmetic
  always_comb begin
    if (op == OP_ADD) begin
      a_r1_add_sum: assert ({flag_carry, result} == {1'b0, opnd_a} + {1'b0, opnd_b});
      a_r4_add_ovf: assert (flag_ovf == ((opnd_a[W-1] == opnd_b[W-1]) && (result[W-1] != opnd_a[W-1])));
    end
    if (op == OP_SUB) begin
      a_r3_borrow:  assert (flag_carry == (opnd_a < opnd_b));
      a_r2_sub:     assert (result == opnd_a - opnd_b);
      a_r4_sub_ovf: assert (flag_ovf == ((opnd_a[W-1] != opnd_b[W-1]) && (result[W-1] != opnd_a[W-1])));
    end
    if (op inside {OP_AND, OP_OR, OP_XOR, OP_NOT})
      a_r9_no_cv: assert (!flag_carry && !flag_ovf);
    if (op == OP_SHL)
      a_r7_shl: assert ({flag_carry, result} == {opnd_a, 1'b0} && !flag_ovf);
    if (op == OP_SHR)
      a_r8_shr: assert ({result, flag_carry} == {1'b0, opnd_a} && !flag_ovf);
    a_r10_zero: assert (flag_zero == (result == '0));
  end
endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0] op_sel;
  logic [7:0] opnd_a, opnd_b, result;
  logic       flag_zero, flag_neg, flag_carry, flag_ovf;

  alu8_core u_alu8_core (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .flag_zero(flag_zero), .flag_neg(flag_neg),
    .flag_carry(flag_carry), .flag_ovf(flag_ovf)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // expected {y, c, v}
  function automatic logic [9:0] model(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    logic [7:0] y;
    logic c, v;
    c = 0; v = 0;
    case (op)
      3'd0: begin s = {1'b0, a} + {1'b0, b}; y = s[7:0]; c = s[8];
              v = (a[7] == b[7]) && (y[7] != a[7]); end
      3'd1: begin y = a - b; c = (a < b);
              v = (a[7] != b[7]) && (y[7] != a[7]); end
      3'd2: y = a & b;
      3'd3: y = a | b;
      3'd4: y = a ^ b;
      3'd5: y = ~a;
      3'd6: begin y = a << 1; c = a[7]; end
      default: begin y = a >> 1; c = a[0]; end
    endcase
    return {y, c, v};
  endfunction

  function automatic string req_y(input logic [2:0] op);
    case (op)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd5: return "R6";
      3'd6: return "R7"; 3'd7: return "R8"; default: return "R5";
    endcase
  endfunction

  function automatic string req_c(input logic [2:0] op);
    case (op)
      3'd0: return "R1"; 3'd1: return "R3"; 3'd6: return "R7";
      3'd7: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s op=%0d a=%02h b=%02h actual=%02h expected=%02h", req, op_sel, opnd_a, opnd_b, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [9:0] e;
    @(posedge clk);
    op_sel = op; opnd_a = a; opnd_b = b;
    @(negedge clk);
    e = model(op, a, b);
    chk(req_y(op), result, e[9:2]);
    chk(req_c(op), {7'd0, flag_carry}, {7'd0, e[1]});
    chk((op < 3'd2) ? "R4" : "R9", {7'd0, flag_ovf}, {7'd0, e[0]});
    chk("R10", {7'd0, flag_zero}, {7'd0, (e[9:2] == 8'd0)});
    chk("R11", {7'd0, flag_neg}, {7'd0, e[9]});
  endtask

  // R12: B has no effect on unary codes
  task automatic b_ignored(input logic [2:0] op, input logic [7:0] a);
    logic [11:0] first;
    @(posedge clk);
    op_sel = op; opnd_a = a; opnd_b = 8'h00;
    @(negedge clk);
    first = {result, flag_zero, flag_neg, flag_carry, flag_ovf};
    opnd_b = 8'hFF;
    @(negedge clk);
    chk("R12", result, first[11:4]);
    chk("R12", {4'd0, flag_zero, flag_neg, flag_carry, flag_ovf}, {4'd0, first[3:0]});
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    op_sel = 3'd0; opnd_a = 8'd0; opnd_b = 8'd0;
    @(negedge clk);
    // idle state: 0 + 0
    chk("R10", {7'd0, flag_zero}, 8'd1);
    chk("R1", result, 8'd0);

    // directed corners
    apply(3'd0, 8'h7F, 8'h01);   // R4 overflow set
    apply(3'd1, 8'h80, 8'h01);   // R4 sub overflow
    apply(3'd1, 8'h00, 8'h01);   // R3 borrow
    apply(3'd0, 8'hFF, 8'h01);   // R1 carry, R10 zero
    apply(3'd1, 8'h55, 8'h55);
    apply(3'd0, 8'h80, 8'h80);
    apply(3'd6, 8'h80, 8'h00);   // R7
    apply(3'd7, 8'h01, 8'h00);   // R8
    apply(3'd5, 8'hFF, 8'h12);   // R6
    for (int op = 2; op <= 4; op++) apply(3'(op), 8'hF0, 8'h3C);

    for (int op = 0; op < 8; op++)
      for (int k = 0; k < 1500; k++)
        apply(3'(op), 8'($urandom), 8'($urandom));

    for (int op = 5; op < 8; op++)
      for (int k = 0; k < 40; k++)
        b_ignored(3'(op), 8'($urandom));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule